// File: doc/BRIEF.md
# Burst Dataphase Termination Controller

This block is the local-side end-of-burst logic for a pipelined bus initiator. The bus side registers its own handshake before reporting a finished dataphase, and it registers the frame signal after the `complete` request arrives. The end-of-burst request must therefore be issued ahead of time. The block takes a burst length on a request channel and counts finished dataphases down. It raises `complete` at the one cycle that makes the bus stop after exactly the programmed number of dataphases.

A burst falls into one of three length classes, and each class has its own timing rule:
- **Single:** a length of 1, where a length of 0 is also treated as 1. `complete` is raised in the cycle the request is accepted.
- **Pair:** a length of 2. `complete` is raised once the data state has lasted one cycle, but only while the local side is not inserting wait states.
- **Long:** a length of 3 or more. `complete` is raised when a completion pulse arrives while the remaining count is three.

Once raised, `complete` is held until the data state ends. A target stop or abort ends the burst at any point. After the data state ends or after a stop, the block returns to idle with `complete` low and the counter cleared.

The request channel follows valid/ready rules. `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must keep `req_valid` and `req_len` stable until the request is taken. All other pins are plain level or pulse controls.

Top module: `burst_term_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken only on a cycle with `req_valid` and `req_ready` both high. A request offered while a burst is active is ignored, and `remaining` keeps its value.
- R2: In the cycle after a request is taken, `remaining` equals `req_len`, or 1 when `req_len` is 0.
- R3: Each `beat_done` pulse seen while `data_phase` is high lowers `remaining` by one in the next cycle. `remaining` never goes below zero.
- R4: For an effective length of 1, `complete` is high in the same cycle the request is taken.
- R5: For a length of 2, `complete` rises in the first cycle that satisfies all of the following: `data_phase` is high, `data_phase` was also high in the previous cycle, and `local_wait` is low.
- R6: For a length of 2, `complete` stays low in every data cycle where `local_wait` is high, until it has first been raised.
- R7: For a length of 3 or more, `complete` first rises in the cycle where `remaining` is 3 and `beat_done` is high.
- R8: Once raised, `complete` stays high every cycle while `data_phase` is high. It is low in the cycle `data_phase` falls.
- R9: When the data state ends, the block returns to idle in the next cycle: `complete` is low, `remaining` is 0 and `req_ready` is high.
- R10: `tgt_stop` during an active burst returns the block to idle in the next cycle, with `remaining` 0 and `req_ready` high, whatever the state of `complete`.
- R11: Attached to a bus that deasserts its frame register one cycle after `complete`, the bus performs exactly the effective programmed number of dataphases. This holds for lengths 1, 2, 3 and longer, with or without local wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_len | input | LEN_W | Programmed dataphase count (0 counts as 1) |
| beat_done | input | 1 | Registered pulse: one dataphase finished on the bus |
| data_phase | input | 1 | Bus side is in its data state |
| local_wait | input | 1 | Local side inserts an initiator wait state |
| tgt_stop | input | 1 | Target disconnect or abort ends the burst |
| complete | output | 1 | Request to end the burst at the next opportunity |
| remaining | output | LEN_W | Dataphases not yet confirmed |

## Verification
`complete` is combinational for the single class and the pair class. For the single class it is checked in the request cycle itself. For the pair class it is checked in the cycle after the data state starts, or the first such cycle without a wait. For the long class, `complete` is checked in the very cycle where a completion pulse meets a count of three. `remaining` is registered, so the load, each decrement and the clears after the data state ends or after a stop are checked one cycle after their cause. The bench samples 1 ns after each falling edge, with the inputs for that cycle already applied, and it compares cycle by cycle against an index counted from the request cycle. A bus model counts the dataphases it actually performs, and a scoreboard compares that count with the programmed length.

// File: rtl/burst_term_pkg.sv
package burst_term_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    BL_SINGLE = 2'd0,
    BL_PAIR   = 2'd1,
    BL_LONG   = 2'd2
  } blen_e;
endpackage

// File: rtl/burst_term_len_class.sv
module burst_term_len_class
  import burst_term_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [LEN_W-1:0] len_in,
  output logic [LEN_W-1:0] len_eff,
  output blen_e            len_cls
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  always_comb begin
    len_eff = (len_in == '0) ? ONE : len_in;
    if (len_eff == ONE)      len_cls = BL_SINGLE;
    else if (len_eff == TWO) len_cls = BL_PAIR;
    else                     len_cls = BL_LONG;
  end
endmodule

// File: rtl/burst_term_counter.sv
module burst_term_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  input  logic             clr,
  output logic [LEN_W-1:0] count,
  output logic             at_three
);
  localparam logic [LEN_W-1:0] THREE = LEN_W'(3);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (load)                 count <= load_val;
    else if (dec && count != '0)   count <= count - ONE;
  end

  assign at_three = (count == THREE);
endmodule

// File: rtl/burst_term_seq.sv
module burst_term_seq
  import burst_term_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  blen_e  cls_in,
  input  logic   data_phase,
  input  logic   tgt_stop,
  output phase_e phase,
  output blen_e  cls,
  output logic   req_ready,
  output logic   fire,
  output logic   clr
);
  phase_e phase_nx;
  logic   ended;
  logic   aborted;

  assign req_ready = (phase == PH_IDLE);
  assign fire      = req_valid && req_ready;
  assign ended     = (phase == PH_DATA) && !data_phase;
  assign aborted   = (phase != PH_IDLE) && tgt_stop;
  assign clr       = ended || aborted;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (fire) phase_nx = PH_ARMED;
      PH_ARMED: if (aborted) phase_nx = PH_IDLE;
                else if (data_phase) phase_nx = PH_DATA;
      PH_DATA:  if (clr) phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cls   <= BL_SINGLE;
    end else begin
      phase <= phase_nx;
      if (fire) cls <= cls_in;
    end
  end
endmodule

// File: rtl/burst_term_finish.sv
module burst_term_finish
  import burst_term_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  blen_e  cls_in,
  input  phase_e phase,
  input  blen_e  cls,
  input  logic   data_phase,
  input  logic   local_wait,
  input  logic   beat_done,
  input  logic   at_three,
  input  logic   clr,
  output logic   complete
);
  logic fin_one;
  logic fin_two;
  logic fin_long;
  logic hold;

  // single: raise with the request, before any transfer is seen
  assign fin_one  = fire && (cls_in == BL_SINGLE);
  // pair: data state entered last cycle and no initiator wait now
  assign fin_two  = (phase == PH_DATA) && (cls == BL_PAIR) && data_phase && !local_wait;
  // long: dataphase n-2 has just been confirmed
  assign fin_long = (phase != PH_IDLE) && (cls == BL_LONG) && at_three && beat_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              hold <= 1'b0;
    else if (clr)                            hold <= 1'b0;
    else if (fin_one || fin_two || fin_long) hold <= 1'b1;
  end

  assign complete = fin_one || ((fin_two || fin_long || hold) && !clr);
endmodule

// File: rtl/burst_term_ctrl.sv
module burst_term_ctrl
  import burst_term_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  input  logic             beat_done,
  input  logic             data_phase,
  input  logic             local_wait,
  input  logic             tgt_stop,
  output logic             complete,
  output logic [LEN_W-1:0] remaining
);
  logic [LEN_W-1:0] len_eff;
  blen_e            cls_in;
  blen_e            cls;
  phase_e           phase;
  logic             fire;
  logic             clr;
  logic             at_three;

  burst_term_len_class #(.LEN_W(LEN_W)) u_cls (
    .len_in  (req_len),
    .len_eff (len_eff),
    .len_cls (cls_in)
  );

  burst_term_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cls_in     (cls_in),
    .data_phase (data_phase),
    .tgt_stop   (tgt_stop),
    .phase      (phase),
    .cls        (cls),
    .req_ready  (req_ready),
    .fire       (fire),
    .clr        (clr)
  );

  burst_term_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire),
    .load_val (len_eff),
    .dec      (beat_done),
    .clr      (clr),
    .count    (remaining),
    .at_three (at_three)
  );

  burst_term_finish u_fin (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .cls_in     (cls_in),
    .phase      (phase),
    .cls        (cls),
    .data_phase (data_phase),
    .local_wait (local_wait),
    .beat_done  (beat_done),
    .at_three   (at_three),
    .clr        (clr),
    .complete   (complete)
  );
endmodule

// File: rtl/burst_term_chk.sv
module burst_term_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             beat_done,
  input logic             data_phase,
  input logic             tgt_stop,
  input logic             complete,
  input logic [LEN_W-1:0] remaining
);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
  localparam logic [LEN_W-1:0] THREE = LEN_W'(3);

  logic [LEN_W-1:0] lat_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_len <= '0;
    else if (req_valid && req_ready) lat_len <= (req_len == '0) ? ONE : req_len;
  end

  // R1
  taken_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> remaining == (($past(req_len) == '0) ? ONE : $past(req_len)));

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && data_phase && !req_ready && !tgt_stop && remaining != '0)
      |=> remaining == $past(remaining) - ONE);

  // R4
  single_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len <= ONE) |-> complete);

  // R7
  long_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(complete) && !req_ready && lat_len >= THREE) |-> (remaining == THREE && beat_done));

  // R8
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && data_phase && !req_ready && !tgt_stop) |=> (complete || !data_phase));

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> remaining == '0);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_stop && !req_ready) |=> (req_ready && remaining == '0));
endmodule

bind burst_term_ctrl burst_term_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_len    (req_len),
  .beat_done  (beat_done),
  .data_phase (data_phase),
  .tgt_stop   (tgt_stop),
  .complete   (complete),
  .remaining  (remaining)
);

// File: tb/test_burst_term_ctrl.sv
`timescale 1ns/1ps
module test_burst_term_ctrl;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [LEN_W-1:0] req_len;
  logic             beat_done;
  logic             data_phase;
  logic             local_wait;
  logic             tgt_stop;
  logic             complete;
  logic [LEN_W-1:0] remaining;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  burst_term_ctrl #(.LEN_W(LEN_W)) i_burst_term_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .beat_done(beat_done), .data_phase(data_phase),
    .local_wait(local_wait), .tgt_stop(tgt_stop), .complete(complete),
    .remaining(remaining)
  );

  // bus model: 0 idle, 1 address, 2 data; frame register drops one cycle after complete
  logic [1:0] bst;
  logic       frame_r;
  int         xcnt;
  logic       bus_done;
  logic       xfer;
  assign xfer       = (bst == 2'd2) && !local_wait && !tgt_stop;
  assign data_phase = (bst == 2'd1) || (bst == 2'd2);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst <= 2'd0; frame_r <= 1'b0; xcnt <= 0; bus_done <= 1'b0; beat_done <= 1'b0;
    end else begin
      beat_done <= xfer;
      bus_done  <= 1'b0;
      case (bst)
        2'd0: if (req_valid && req_ready) begin
          bst <= 2'd1; frame_r <= !complete; xcnt <= 0;
        end
        2'd1: begin
          bst <= tgt_stop ? 2'd0 : 2'd2;
          frame_r <= frame_r && !(complete && !local_wait);
        end
        default: begin
          if (tgt_stop) bst <= 2'd0;
          else begin
            frame_r <= frame_r && !(complete && !local_wait);
            if (xfer) begin
              xcnt <= xcnt + 1;
              if (!frame_r) begin bst <= 2'd0; bus_done <= 1'b1; end
            end
          end
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor: dataphases performed vs programmed (R11)
  always @(negedge clk) begin
    if (rst_n && bus_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected burst", xcnt, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(xcnt == e, "R11 dataphase count", xcnt, e);
      end
    end
  end

  task automatic run_burst(input int len, input logic [31:0] wmask,
                           input bit stray, input int stop_c);
    int  eff;
    int  c;
    bit  risen;
    bit  seen;
    bit  exp;
    bit  p_beat;
    bit  p_dp;
    int  p_rem;
    string tag;
    eff = (len == 0) ? 1 : len;
    if (stop_c < 0) exp_q.push_back(eff);
    c = 0; risen = 0; seen = 0; p_beat = 0; p_dp = 0; p_rem = 0;
    @(negedge clk);
    req_valid = 1'b1; req_len = LEN_W'(len); local_wait = wmask[0]; tgt_stop = 1'b0;
    forever begin
      #1;
      if (!tgt_stop) begin
        if (c == 0)       begin exp = (eff == 1); tag = "R4 single raise"; end
        else if (risen)   begin exp = data_phase; tag = "R8 hold until data end"; end
        else if (eff == 2) begin
          exp = (c >= 2) && data_phase && !local_wait;
          tag = local_wait ? "R6 wait holds off" : "R5 pair raise";
        end
        else if (eff >= 3) begin
          exp = (remaining == LEN_W'(3)) && beat_done && data_phase;
          tag = "R7 long raise";
        end
        else begin exp = 1'b0; tag = "R8 stays low"; end
        chk(complete == exp, tag, int'(complete), int'(exp));
      end
      if (complete) risen = 1;
      if (c == 1) begin
        chk(req_ready == 1'b0, "R1 busy not ready", int'(req_ready), 0);
        chk(remaining == LEN_W'(eff), "R2 load length", int'(remaining), eff);
      end
      if (stray && c == 3)
        chk(remaining == LEN_W'(eff), "R1 stray request ignored", int'(remaining), eff);
      if (c >= 2 && p_beat && p_dp && p_rem > 0)
        chk(int'(remaining) == p_rem - 1, "R3 decrement", int'(remaining), p_rem - 1);
      if (data_phase) seen = 1;
      if (seen && !data_phase) break;
      if (c > 60) begin chk(1'b0, "R11 burst did not end", c, eff); break; end
      p_beat = beat_done; p_dp = data_phase && !tgt_stop; p_rem = int'(remaining);
      @(negedge clk);
      c++;
      req_valid  = stray && (c == 1 || c == 2);
      if (stray && c == 1) req_len = LEN_W'(9);
      local_wait = (c < 32) ? wmask[c] : 1'b0;
      tgt_stop   = (c == stop_c);
    end
    tgt_stop = 1'b0; local_wait = 1'b0; req_valid = 1'b0;
    if (stop_c >= 0) begin
      chk(req_ready == 1'b1, "R10 stop returns idle", int'(req_ready), 1);
      chk(remaining == '0, "R10 stop clears count", int'(remaining), 0);
    end
    @(negedge clk); #1;
    tag = (stop_c >= 0) ? "R10 idle after stop" : "R9 idle after burst";
    chk(complete == 1'b0, tag, int'(complete), 0);
    chk(remaining == '0, tag, int'(remaining), 0);
    chk(req_ready == 1'b1, tag, int'(req_ready), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_len = '0;
    local_wait = 1'b0; tgt_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(complete == 1'b0, "R9 reset complete low", int'(complete), 0);
    chk(remaining == '0, "R9 reset count zero", int'(remaining), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);

    run_burst(1, 32'h0, 0, -1);
    run_burst(0, 32'h0, 0, -1);
    run_burst(1, 32'h0000_000C, 0, -1);
    run_burst(2, 32'h0, 0, -1);
    run_burst(2, 32'h0000_000C, 0, -1);
    run_burst(3, 32'h0, 0, -1);
    run_burst(3, 32'h0000_0028, 0, -1);
    run_burst(4, 32'h0, 1, -1);
    run_burst(8, 32'h0, 0, -1);
    run_burst(8, 32'h0000_0A94, 0, -1);
    run_burst(6, 32'h0, 0, 4);
    run_burst(5, 32'h0000_0040, 0, -1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all bursts completed", exp_q.size(), 0);
    report();
  end
endmodule